// File: doc/BRIEF.md
# WiMAX Deinterleaver Read-Address Generator

This block produces, one per clock, the read addresses that a block deinterleaver in a mobile broadband receiver uses to pull soft bits out of its buffer in de-permuted order. A block is launched by a one-cycle start strobe together with a modulation select, a code-rate select and a size select. A small selector turns that triple into a column count, which is the block depth divided by the fixed row count of 16. An FSM controller then walks a row counter and a column-position counter. Each address is formed from those counters and a per-row cyclic rotation of column positions, with no divider and no multiplier on the address path.

Columns are grouped in groups of one, two or three, depending on modulation. Inside each group the column taken for a position is rotated by the row number modulo the group size. The rotation term is kept in a wrap-around counter that advances once per row. The low four address bits are always the row, and the upper bits are the rotated column.

A triple that names no permitted depth gives a one-cycle error indication and no addresses. After the last address of a block, a one-cycle completion pulse follows.

Top module: `dil_addr_gen`

## Requirements
- R1: While reset is asserted, and after its release until a start is accepted, addr_valid, done, err and busy are all low.
- R2: Encodings are mod_sel 0 = QPSK, 1 = 16-QAM, 2 = 64-QAM, and rate_sel 0 = 1/2, 1 = 2/3, 2 = 3/4. size_sel k picks the (k+1)-th entry of the ascending depth list for that pair. The lists are: QPSK 1/2 {96,192,288,384,480,576}, QPSK 3/4 {144,288,432,576}, 16-QAM 1/2 {192,384,576}, 16-QAM 3/4 {288,576}, 64-QAM 1/2 {288,576}, 64-QAM 2/3 {384}, 64-QAM 3/4 {432}. An accepted block emits exactly that depth of valid addresses.
- R3: Addresses are emitted row by row, for rows 0 to 15, with position p from 0 to depth/16−1 advancing fastest. Each address equals row + 16·column, so bits [3:0] carry the row and bits [9:4] carry the column.
- R4: For QPSK the column equals the position p.
- R5: For 16-QAM the column equals p on even rows. On odd rows the two columns of each pair are swapped (row 1 starts 17, 1, 49, 33).
- R6: For 64-QAM, with g = p/3 and q = p mod 3, the column is 3g + ((q + row) mod 3). Row 1 starts 17, 33, 1, 65, 81, 49.
- R7: The first address is valid in the cycle after the clock edge that accepts start, and valid stays high for depth consecutive cycles.
- R8: done is high for exactly one cycle, directly after the last valid address. busy is high from the first valid cycle through the done cycle, and also during an error cycle.
- R9: A start with an unlisted triple (mod_sel 3, rate_sel 3, 2/3 with QPSK or 16-QAM, or size_sel beyond the list) raises err for one cycle in the next cycle, with no valid address and no done.
- R10: mod_sel, rate_sel and size_sel are sampled only when a start is accepted. A start while busy, including on the last address or the done cycle, is ignored and does not disturb the running block.
- R11: A start present in the first idle cycle after done is accepted, and a new block begins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch request, accepted only when idle |
| mod_sel | input | 2 | Modulation select (R2 encoding) |
| rate_sel | input | 2 | Code-rate select (R2 encoding) |
| size_sel | input | 3 | Index into the depth list of the selected pair |
| addr | output | 10 | Read address, row in bits [3:0], column above |
| addr_valid | output | 1 | addr carries a valid address this cycle |
| done | output | 1 | One-cycle pulse after the last address of a block |
| err | output | 1 | One-cycle pulse for a rejected triple |
| busy | output | 1 | Block or error cycle in progress |

## Verification
Two functions can meet in one cycle: a new start request can coincide with the final address or with the done pulse of the running block. The bench provokes this by holding start high through a whole block with different select values. It also pulses start in the middle of a block. The behavioural model then expects the busy request to be ignored, exactly one restart in the cycle after the idle cycle that follows done, and addresses for the originally sampled configuration only.

// File: rtl/dil_pkg.sv
package dil_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_BAD  = 2'd3
  } dil_state_e;

  localparam logic [1:0] MODSEL_QPSK  = 2'd0;
  localparam logic [1:0] MODSEL_QAM16 = 2'd1;
  localparam logic [1:0] MODSEL_QAM64 = 2'd2;

  localparam logic [1:0] RATESEL_HALF     = 2'd0;
  localparam logic [1:0] RATESEL_TWOTHIRD = 2'd1;
  localparam logic [1:0] RATESEL_THREEQTR = 2'd2;

endpackage

// File: rtl/dil_depth_lut.sv
module dil_depth_lut #(
  parameter int COL_W = 6,
  parameter int SEL_W = 3
) (
  input  logic [1:0]       mod_sel,
  input  logic [1:0]       rate_sel,
  input  logic [SEL_W-1:0] size_sel,
  output logic             cfg_ok,
  output logic [1:0]       grp,
  output logic [COL_W-1:0] ncol
);
  import dil_pkg::*;

  localparam int PROD_W = COL_W + SEL_W + 1;

  logic [COL_W-1:0]  step;
  logic [SEL_W:0]    count;
  logic [SEL_W:0]    size_p1;
  logic [PROD_W-1:0] prod;

  // Each permitted list is an arithmetic run: step, 2*step, ...
  always_comb begin
    step  = '0;
    count = '0;
    grp   = 2'd1;
    unique case ({mod_sel, rate_sel})
      {MODSEL_QPSK,  RATESEL_HALF}:     begin step = COL_W'(6);  count = (SEL_W+1)'(6); grp = 2'd1; end
      {MODSEL_QPSK,  RATESEL_THREEQTR}: begin step = COL_W'(9);  count = (SEL_W+1)'(4); grp = 2'd1; end
      {MODSEL_QAM16, RATESEL_HALF}:     begin step = COL_W'(12); count = (SEL_W+1)'(3); grp = 2'd2; end
      {MODSEL_QAM16, RATESEL_THREEQTR}: begin step = COL_W'(18); count = (SEL_W+1)'(2); grp = 2'd2; end
      {MODSEL_QAM64, RATESEL_HALF}:     begin step = COL_W'(18); count = (SEL_W+1)'(2); grp = 2'd3; end
      {MODSEL_QAM64, RATESEL_TWOTHIRD}: begin step = COL_W'(24); count = (SEL_W+1)'(1); grp = 2'd3; end
      {MODSEL_QAM64, RATESEL_THREEQTR}: begin step = COL_W'(27); count = (SEL_W+1)'(1); grp = 2'd3; end
      default: begin step = '0; count = '0; grp = 2'd1; end
    endcase
  end

  assign size_p1 = {1'b0, size_sel} + {{SEL_W{1'b0}}, 1'b1};
  assign prod    = {{(SEL_W+1){1'b0}}, step} * {{COL_W{1'b0}}, size_p1};
  assign ncol    = prod[COL_W-1:0];
  assign cfg_ok  = (count != '0) && ({1'b0, size_sel} < count);

endmodule

// File: rtl/dil_ctrl.sv
module dil_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cfg_ok,
  input  logic last,
  output logic load,
  output logic adv,
  output logic busy,
  output logic valid,
  output logic done,
  output logic err
);
  import dil_pkg::*;

  dil_state_e state_q;
  dil_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = cfg_ok ? ST_RUN : ST_BAD;
      ST_RUN:  if (last)  state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      ST_BAD:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign load  = (state_q == ST_IDLE) && start && cfg_ok;
  assign adv   = (state_q == ST_RUN);
  assign valid = (state_q == ST_RUN);
  assign done  = (state_q == ST_FIN);
  assign err   = (state_q == ST_BAD);
  assign busy  = (state_q != ST_IDLE);

endmodule

// File: rtl/dil_addr_path.sv
module dil_addr_path #(
  parameter int ROW_W = 4,
  parameter int COL_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   adv,
  input  logic [1:0]             grp_in,
  input  logic [COL_W-1:0]       ncol_in,
  output logic [ROW_W+COL_W-1:0] addr,
  output logic                   last
);
  localparam logic [ROW_W-1:0] ROW_LAST = {ROW_W{1'b1}};
  localparam logic [COL_W-1:0] COL_ONE  = {{(COL_W-1){1'b0}}, 1'b1};

  // configuration captured on an accepted start
  logic [1:0]       grp_q;
  logic [COL_W-1:0] ncol_q;

  // walking counters
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] pos_q, pos_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [1:0]       sub_q, sub_d;
  logic [1:0]       rot_q, rot_d;

  logic             cnt_en;
  logic             row_end;
  logic [2:0]       sum;
  logic [2:0]       lane;
  logic [COL_W-1:0] col;

  assign cnt_en  = load | adv;
  assign row_end = (pos_q == ncol_q - COL_ONE);
  assign last    = row_end && (row_q == ROW_LAST);

  always_comb begin
    row_d  = row_q;
    pos_d  = pos_q;
    base_d = base_q;
    sub_d  = sub_q;
    rot_d  = rot_q;
    if (load) begin
      row_d  = '0;
      pos_d  = '0;
      base_d = '0;
      sub_d  = '0;
      rot_d  = '0;
    end else if (adv) begin
      if (row_end) begin
        row_d  = row_q + {{(ROW_W-1){1'b0}}, 1'b1};
        pos_d  = '0;
        base_d = '0;
        sub_d  = '0;
        rot_d  = (rot_q == grp_q - 2'd1) ? 2'd0 : rot_q + 2'd1;
      end else begin
        pos_d = pos_q + COL_ONE;
        if (sub_q == grp_q - 2'd1) begin
          sub_d  = 2'd0;
          base_d = base_q + {{(COL_W-2){1'b0}}, grp_q};
        end else begin
          sub_d = sub_q + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= 2'd1;
      ncol_q <= '0;
    end else if (load) begin
      grp_q  <= grp_in;
      ncol_q <= ncol_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      pos_q  <= '0;
      base_q <= '0;
      sub_q  <= '0;
      rot_q  <= '0;
    end else if (cnt_en) begin
      row_q  <= row_d;
      pos_q  <= pos_d;
      base_q <= base_d;
      sub_q  <= sub_d;
      rot_q  <= rot_d;
    end
  end

  // rotated lane inside the group: (sub + rot) mod grp, both below grp
  assign sum  = {1'b0, sub_q} + {1'b0, rot_q};
  assign lane = (sum >= {1'b0, grp_q}) ? (sum - {1'b0, grp_q}) : sum;
  assign col  = base_q + {{(COL_W-3){1'b0}}, lane};
  assign addr = {col, row_q};

endmodule

// File: rtl/dil_addr_gen.sv
module dil_addr_gen #(
  parameter int ROW_W = 4,
  parameter int COL_W = 6,
  parameter int SEL_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             mod_sel,
  input  logic [1:0]             rate_sel,
  input  logic [SEL_W-1:0]       size_sel,
  output logic [ROW_W+COL_W-1:0] addr,
  output logic                   addr_valid,
  output logic                   done,
  output logic                   err,
  output logic                   busy
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             cfg_ok;
  logic [1:0]       grp;
  logic [COL_W-1:0] ncol;
  logic             load;
  logic             adv;
  logic             last;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dil_depth_lut #(.COL_W(COL_W), .SEL_W(SEL_W)) u_lut (
    .mod_sel  (mod_sel),
    .rate_sel (rate_sel),
    .size_sel (size_sel),
    .cfg_ok   (cfg_ok),
    .grp      (grp),
    .ncol     (ncol)
  );

  dil_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start),
    .cfg_ok (cfg_ok),
    .last   (last),
    .load   (load),
    .adv    (adv),
    .busy   (busy),
    .valid  (addr_valid),
    .done   (done),
    .err    (err)
  );

  dil_addr_path #(.ROW_W(ROW_W), .COL_W(COL_W)) u_path (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (load),
    .adv     (adv),
    .grp_in  (grp),
    .ncol_in (ncol),
    .addr    (addr),
    .last    (last)
  );

endmodule

// File: rtl/dil_addr_chk.sv
module dil_addr_chk #(
  parameter int ROW_W    = 4,
  parameter int COL_W    = 6,
  parameter int MAX_COLS = 36
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic [ROW_W+COL_W-1:0] addr,
  input logic                   addr_valid,
  input logic                   done,
  input logic                   err,
  input logic                   busy
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam logic [ADDR_W-1:0] ADDR_LIMIT = ADDR_W'(MAX_COLS * (2 ** ROW_W));

  p_addr_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (addr < ADDR_LIMIT));

  p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(addr_valid)) |->
      ((addr[ROW_W-1:0] == $past(addr[ROW_W-1:0])) ||
       (addr[ROW_W-1:0] == $past(addr[ROW_W-1:0]) + ROW_W'(1))));

  p_done_after_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(addr_valid));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid || done || err) |-> busy);

  p_err_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(start));

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!addr_valid && !done));

  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (!err && !addr_valid));

  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && start) |=> !err);

endmodule

bind dil_addr_gen dil_addr_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .addr       (addr),
  .addr_valid (addr_valid),
  .done       (done),
  .err        (err),
  .busy       (busy)
);

// File: tb/sim_dil_addr_gen.sv
module sim_dil_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NONE = -9;
  localparam int WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] mod_sel = 2'd0;
  logic [1:0] rate_sel = 2'd0;
  logic [2:0] size_sel = 3'd0;
  logic [9:0] addr;
  logic       addr_valid, done, err, busy;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string phase = "R1";

  int exp_q[$];
  int cur = NONE;
  int run_mod = 0;
  int run_depth = 0;
  int valid_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dil_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mod_sel(mod_sel),
    .rate_sel(rate_sel), .size_sel(size_sel), .addr(addr),
    .addr_valid(addr_valid), .done(done), .err(err), .busy(busy)
  );

  // R2 depth lists, written as block depths
  function automatic int ref_depth(int m, int r, int k);
    int l[$];
    if      (m == 0 && r == 0) l = '{96, 192, 288, 384, 480, 576};
    else if (m == 0 && r == 2) l = '{144, 288, 432, 576};
    else if (m == 1 && r == 0) l = '{192, 384, 576};
    else if (m == 1 && r == 2) l = '{288, 576};
    else if (m == 2 && r == 0) l = '{288, 576};
    else if (m == 2 && r == 1) l = '{384};
    else if (m == 2 && r == 2) l = '{432};
    if (k < l.size()) return l[k];
    return 0;
  endfunction

  function automatic void fill(int m, int r, int k);
    int d;
    int s;
    d = ref_depth(m, r, k);
    if (d == 0) begin
      exp_q.push_back(-2);
      return;
    end
    s = m + 1;
    for (int row = 0; row < 16; row++)
      for (int p = 0; p < d / 16; p++)
        exp_q.push_back(row + 16 * (s * (p / s) + ((p % s) + row) % s));
    exp_q.push_back(-1);
  endfunction

  // reference model: advances on every clock edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      cur = NONE;
      exp_q.delete();
    end else begin
      if (cur == NONE && start) begin
        fill(int'(mod_sel), int'(rate_sel), int'(size_sel));
        run_mod   = int'(mod_sel);
        run_depth = ref_depth(int'(mod_sel), int'(rate_sel), int'(size_sel));
        valid_cnt = 0;
      end
      cur = (exp_q.size() > 0) ? exp_q.pop_front() : NONE;
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] act=%0d exp=%0d t=%0t", req, phase, act, expv, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    string atag;
    atag = (run_mod == 0) ? "R3/R4 addr" : (run_mod == 1) ? "R3/R5 addr" : "R3/R6 addr";
    check(addr_valid == (cur >= 0), "R7 valid", int'(addr_valid), int'(cur >= 0));
    check(done == (cur == -1), "R8 done", int'(done), int'(cur == -1));
    check(err == (cur == -2), "R9 err", int'(err), int'(cur == -2));
    check(busy == (cur != NONE), "R8 busy", int'(busy), int'(cur != NONE));
    if (cur >= 0) check(int'(addr) == cur, atag, int'(addr), cur);
    if (addr_valid) valid_cnt++;
    if (cur == -1) check(valid_cnt == run_depth, "R2 count", valid_cnt, run_depth);
  end

  always @(posedge clk) begin
    if (cycles > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic kick(int m, int r, int k);
    @(negedge clk);
    mod_sel = 2'(m); rate_sel = 2'(r); size_sel = 3'(k);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (cur != NONE || exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_block(int m, int r, int k);
    kick(m, r, k);
    wait_idle();
  endtask

  initial begin
    // R1: reset and post-release quiet state
    phase = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    phase = "R4";
    for (int k = 0; k < 6; k++) run_block(0, 0, k);
    for (int k = 0; k < 4; k++) run_block(0, 2, k);

    phase = "R5";
    for (int k = 0; k < 3; k++) run_block(1, 0, k);
    for (int k = 0; k < 2; k++) run_block(1, 2, k);

    phase = "R6";
    for (int k = 0; k < 2; k++) run_block(2, 0, k);
    run_block(2, 1, 0);
    run_block(2, 2, 0);

    // R9: rejected triples
    phase = "R9";
    run_block(3, 0, 0);
    run_block(0, 3, 0);
    run_block(0, 1, 0);
    run_block(1, 1, 0);
    run_block(0, 0, 6);
    run_block(2, 1, 1);
    run_block(1, 2, 7);

    // R10: start while busy, inputs changed mid-block
    phase = "R10";
    kick(2, 2, 0);
    repeat (50) @(negedge clk);
    mod_sel = 2'd0; rate_sel = 2'd0; size_sel = 3'd5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rate_sel = 2'd3;
    wait_idle();

    // R10/R11: start held over last address and done, then one restart
    phase = "R11";
    @(negedge clk);
    mod_sel = 2'd1; rate_sel = 2'd2; size_sel = 3'd0;
    start = 1'b1;
    @(negedge clk);
    mod_sel = 2'd2; rate_sel = 2'd0; size_sel = 3'd0;
    while (!done) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule